// File: doc/BRIEF.md
# Floating-Point Status and Trap Controller

This block holds the 32-bit control and status word that sits beside a floating-point datapath. It decodes the word into the rounding-mode and flush-to-zero controls that steer the arithmetic. After each completed operation it folds the raw exception indications into the status fields. When an enabled exception has been recorded, it issues a one-cycle trap request that carries a fixed exception code.

Software loads the word through a write strobe, and a fixed writable-bit mask is applied on that load. The datapath signals each finished arithmetic, conversion or compare operation with a completion strobe and presents five raw indications with it: invalid, divide-by-zero, overflow, underflow and inexact. A compare also presents its relation: equal, greater or unordered. An ordered compare only updates a condition bit. An unordered compare is handled like an arithmetic result.

Word layout:
- bits [1:0]: rounding mode.
- bits [6:2]: last-operation flags.
- bits [11:7]: trap enables.
- bits [16:12]: accumulated causes.
- bit 18: denormal flush.

In each 5-bit group, from its lowest bit upward, the order is inexact, underflow, overflow, divide-by-zero, invalid. The raw exception input uses the same order, with bit 0 for inexact and bit 4 for invalid.

Top module: `fpsc_ctrl`

## Requirements
- R1: After synchronous reset, the control word is 0, `trap_req` is 0, `trap_code` is 0 and `t_bit` is 0.
- R2: A write (`wr_en`=1) stores `wr_data & 32'h0005_FFFF` into the control word on the next edge.
- R3: `rnd_zero` is 1 exactly when control word bits [1:0] equal 2'b01 (round toward zero). Every other code gives 0, which means round to nearest even.
- R4: `flush_zero` follows control word bit 18.
- R5: On a completed non-compare operation, the flag field [6:2] is replaced by the raw exception vector. This includes the case where the vector is zero, which clears the field.
- R6: If the raw vector is non-zero, it is ORed into the cause field [16:12]. If the vector is zero, the cause field is left unchanged.
- R7: A trap request is raised when an operation with a non-zero raw vector leaves (cause AND enable) non-zero. The request is a one-cycle pulse in the cycle after the completion strobe, and `trap_code` shows 12'h120 exactly while `trap_req` is high. An operation with a zero raw vector never traps.
- R8: An ordered compare writes `t_bit` from `rel_eq` (when `cmp_gt_sel`=0) or from `rel_gt` (when `cmp_gt_sel`=1). It leaves the control word untouched and raises no trap, whatever raw vector is present.
- R9: An unordered compare updates flags, causes and trap exactly as in R5 to R7 and leaves `t_bit` unchanged.
- R10: When `wr_en` and `op_done` are high in the same cycle, the write wins. The operation is dropped, with no trap and no change to `t_bit`.
- R11: With neither `wr_en` nor `op_done` high, the control word and `t_bit` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software load of the control word |
| wr_data | input | 32 | Value to load (masked) |
| op_done | input | 1 | Datapath operation complete strobe |
| op_is_cmp | input | 1 | Completed operation is a compare |
| cmp_gt_sel | input | 1 | Compare kind: 0 equal, 1 greater-than |
| rel_eq | input | 1 | Compare relation equal |
| rel_gt | input | 1 | Compare relation greater |
| rel_unord | input | 1 | Compare relation unordered |
| exc_raw | input | 5 | Raw exceptions {invalid, div0, overflow, underflow, inexact} |
| ctl_word | output | 32 | Current control/status word |
| rnd_zero | output | 1 | Datapath rounding: 1 toward zero, 0 nearest even |
| flush_zero | output | 1 | Datapath denormal flush control |
| t_bit | output | 1 | Compare condition bit |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code while trap is requested, else 0 |

## Verification
Every status field is visible on `ctl_word` one edge after the event that changed it. A wrong flag clear, a lost cause bit or a misplaced shift therefore shows up in the sample right after the completion strobe. A corrupted enable or cause field shows up as a missing trap pulse or an extra one in that same cycle. It can also surface later as a wrong trap when an operation with a zero raw vector leaves the pulse low. Ordering faults between software writes and datapath updates appear as a masked value that differs from what was written.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    parameter int WORD_W = 32;
    parameter int EXC_W  = 5;
    parameter int CODE_W = 12;
    parameter int RM_W   = 2;

    localparam int RM_LSB    = 0;
    localparam int FLAG_LSB  = RM_LSB + RM_W;
    localparam int EN_LSB    = FLAG_LSB + EXC_W;
    localparam int CAUSE_LSB = EN_LSB + EXC_W;
    localparam int DN_BIT    = CAUSE_LSB + EXC_W + 1;

    localparam logic [WORD_W-1:0] WR_MASK   = 32'h0005_FFFF;
    localparam logic [RM_W-1:0]   RM_ZERO   = 2'b01;
    localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;

    typedef enum logic {RND_NEAREST = 1'b0, RND_TOWARD_ZERO = 1'b1} rnd_e;

    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
        logic inx;
    } exc_t;

    function automatic logic [EXC_W-1:0] get_grp(input logic [WORD_W-1:0] w, input int lsb);
        return w[lsb +: EXC_W];
    endfunction
endpackage

// File: rtl/fpsc_mode_decode.sv
module fpsc_mode_decode
    import fpsc_pkg::*;
(
    input  logic [WORD_W-1:0] ctl,
    output rnd_e              rnd_mode,
    output logic              flush
);
    always_comb begin
        rnd_mode = (ctl[RM_LSB +: RM_W] == RM_ZERO) ? RND_TOWARD_ZERO : RND_NEAREST;
        flush    = ctl[DN_BIT];
    end
endmodule

// File: rtl/fpsc_status_next.sv
module fpsc_status_next
    import fpsc_pkg::*;
(
    input  logic [WORD_W-1:0] ctl_cur,
    input  exc_t              exc,
    output logic [WORD_W-1:0] ctl_upd,
    output logic              trap_hit
);
    logic [EXC_W-1:0] raw;
    logic [EXC_W-1:0] cause_new;
    logic [EXC_W-1:0] enables;
    logic             any_exc;

    always_comb begin
        raw       = exc;
        any_exc   = |raw;
        enables   = get_grp(ctl_cur, EN_LSB);
        cause_new = get_grp(ctl_cur, CAUSE_LSB) | (any_exc ? raw : '0);
        ctl_upd   = ctl_cur;
        ctl_upd[FLAG_LSB +: EXC_W]  = raw;
        ctl_upd[CAUSE_LSB +: EXC_W] = cause_new;
        trap_hit  = any_exc && |(cause_new & enables);
    end
endmodule

// File: rtl/fpsc_ctrl.sv
module fpsc_ctrl
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              op_done,
    input  logic              op_is_cmp,
    input  logic              cmp_gt_sel,
    input  logic              rel_eq,
    input  logic              rel_gt,
    input  logic              rel_unord,
    input  logic [4:0]        exc_raw,
    output logic [31:0]       ctl_word,
    output logic              rnd_zero,
    output logic              flush_zero,
    output logic              t_bit,
    output logic              trap_req,
    output logic [11:0]       trap_code
);
    logic [WORD_W-1:0] ctl_q;
    logic [WORD_W-1:0] ctl_upd;
    logic              t_q;
    logic              trap_q;
    logic              trap_hit;
    logic              status_op;
    logic              ordered_cmp;
    rnd_e              rnd_mode;

    fpsc_status_next u_next (
        .ctl_cur (ctl_q),
        .exc     (exc_t'(exc_raw)),
        .ctl_upd (ctl_upd),
        .trap_hit(trap_hit)
    );

    fpsc_mode_decode u_dec (
        .ctl     (ctl_q),
        .rnd_mode(rnd_mode),
        .flush   (flush_zero)
    );

    always_comb begin
        status_op   = op_done && !wr_en && (!op_is_cmp || rel_unord);
        ordered_cmp = op_done && !wr_en && op_is_cmp && !rel_unord;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            t_q    <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            trap_q <= status_op && trap_hit;
            if (wr_en) begin
                ctl_q <= wr_data & WR_MASK;
            end else if (status_op) begin
                ctl_q <= ctl_upd;
            end
            if (ordered_cmp) begin
                t_q <= cmp_gt_sel ? rel_gt : rel_eq;
            end
        end
    end

    assign ctl_word  = ctl_q;
    assign rnd_zero  = (rnd_mode == RND_TOWARD_ZERO);
    assign t_bit     = t_q;
    assign trap_req  = trap_q;
    assign trap_code = trap_q ? TRAP_CODE : '0;
endmodule

// File: rtl/fpsc_ctrl_chk.sv
module fpsc_ctrl_chk
    import fpsc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_done,
    input logic        op_is_cmp,
    input logic        rel_unord,
    input logic [31:0] ctl_word,
    input logic        t_bit,
    input logic        trap_req,
    input logic [11:0] trap_code
);
    // R2
    wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ctl_word == ($past(wr_data) & WR_MASK));

    // R7
    trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req);

    // R7
    trap_code_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req ? (trap_code == TRAP_CODE) : (trap_code == '0));

    // R10
    trap_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_req) |-> $past(op_done) && !$past(wr_en));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !op_done) |=> $stable(ctl_word) && $stable(t_bit));

    // R8
    ordered_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_is_cmp && !rel_unord && !wr_en) |=> $stable(ctl_word) && !trap_req);
endmodule

bind fpsc_ctrl fpsc_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .op_done  (op_done),
    .op_is_cmp(op_is_cmp),
    .rel_unord(rel_unord),
    .ctl_word (ctl_word),
    .t_bit    (t_bit),
    .trap_req (trap_req),
    .trap_code(trap_code)
);

// File: tb/sim_fpsc_ctrl.sv
`timescale 1ns/1ps
module sim_fpsc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic        cmp_gt_sel = 1'b0;
    logic        rel_eq = 1'b0;
    logic        rel_gt = 1'b0;
    logic        rel_unord = 1'b0;
    logic [4:0]  exc_raw = '0;
    logic [31:0] ctl_word;
    logic        rnd_zero, flush_zero, t_bit, trap_req;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fpsc_ctrl u0 (.*);

    localparam int NV = 8;
    localparam logic [31:0] PRE [NV] = '{32'h0, 32'h80, 32'h7C, 32'h1080,
                                         32'h1000, 32'h400, 32'h200, 32'hFFFF_FFFF};
    localparam logic [4:0]  EXC [NV] = '{5'b00001, 5'b00001, 5'b00000, 5'b00000,
                                         5'b10000, 5'b01000, 5'b00011, 5'b11111};
    localparam logic [31:0] EXP [NV] = '{32'h1004, 32'h1084, 32'h0, 32'h1080,
                                         32'h11040, 32'h8420, 32'h320C, 32'h0005_FFFF};
    localparam logic        TRP [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_op(input logic [4:0] e, input logic cmp, input logic gsel,
                         input logic eq, input logic gt, input logic un);
        @(negedge clk);
        op_done = 1'b1; exc_raw = e; op_is_cmp = cmp; cmp_gt_sel = gsel;
        rel_eq = eq; rel_gt = gt; rel_unord = un;
        @(negedge clk);
        op_done = 1'b0; exc_raw = '0; op_is_cmp = 1'b0;
        rel_eq = 1'b0; rel_gt = 1'b0; rel_unord = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 word", ctl_word, 32'h0);
        chk("R1 trap", {31'b0, trap_req}, 32'h0);
        chk("R1 code", {20'b0, trap_code}, 32'h0);
        chk("R1 tbit", {31'b0, t_bit}, 32'h0);

        // R2 R5 R6 R7 table walk
        for (int k = 0; k < NV; k++) begin
            write_word(PRE[k]);
            chk("R2 masked load", ctl_word, PRE[k] & 32'h0005_FFFF);
            do_op(EXC[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R5 R6 status update", ctl_word, EXP[k]);
            chk("R7 trap pulse", {31'b0, trap_req}, {31'b0, TRP[k]});
            chk("R7 trap code", {20'b0, trap_code}, TRP[k] ? 32'h120 : 32'h0);
            @(negedge clk);
            chk("R7 pulse ends", {31'b0, trap_req}, 32'h0);
        end

        // R3 rounding decode
        write_word(32'h1);
        chk("R3 rtz code", {31'b0, rnd_zero}, 32'h1);
        write_word(32'h3);
        chk("R3 code 3", {31'b0, rnd_zero}, 32'h0);
        write_word(32'h2);
        chk("R3 code 2", {31'b0, rnd_zero}, 32'h0);
        // R4 flush
        write_word(32'h0004_0000);
        chk("R4 flush on", {31'b0, flush_zero}, 32'h1);
        write_word(32'h0);
        chk("R4 flush off", {31'b0, flush_zero}, 32'h0);

        // R8 ordered compare, V enabled and raw V present: no status, no trap
        write_word(32'h800);
        do_op(5'b10000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 eq tbit", {31'b0, t_bit}, 32'h1);
        chk("R8 word untouched", ctl_word, 32'h800);
        chk("R8 no trap", {31'b0, trap_req}, 32'h0);
        do_op(5'b00000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 gt tbit", {31'b0, t_bit}, 32'h0);

        // R9 unordered compare: status update and trap, tbit kept
        do_op(5'b00000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        do_op(5'b10000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 status", ctl_word, 32'h10840);
        chk("R9 trap", {31'b0, trap_req}, 32'h1);
        chk("R9 tbit kept", {31'b0, t_bit}, 32'h1);

        // R10 write wins over simultaneous op
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h80; op_done = 1'b1; exc_raw = 5'b00001;
        op_is_cmp = 1'b1; rel_eq = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; exc_raw = '0; op_is_cmp = 1'b0;
        chk("R10 word", ctl_word, 32'h80);
        chk("R10 no trap", {31'b0, trap_req}, 32'h0);
        chk("R10 tbit", {31'b0, t_bit}, 32'h1);

        // R11 idle hold
        repeat (4) @(negedge clk);
        chk("R11 hold", ctl_word, 32'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule